// File: doc/BRIEF.md
# Interrupt Pending-State Clear Register Bank

This block keeps the pending and active state for a bank of shared peripheral interrupts in an extended interrupt range. Each interrupt has one bit in a 32-bit word. The words are reached through two windows on a simple register bus. A write of 1 in the clear window removes software-held pending state. A write of 1 in the set window makes an interrupt pending. A read of either window returns the pending view of the addressed word.

Hardware pending state comes from per-interrupt input lines. A line can be configured as edge-sensitive or level-sensitive. A level-sensitive line that is still high keeps its interrupt pending whatever software writes. A pulse-based activate/deactivate handshake moves interrupts into and out of the active state.

Each bus access carries a non-secure qualifier. A global control can switch the security split off. A range control sets how many words exist, and an enable control can turn the whole extended range off. Bits that must not be reached read as zero and ignore writes. Priority, routing and the CPU side sit outside this block.

Top module: `ipc_bank`

## Requirements
- R1: Clear word n is at byte address 0x1800+4n and set word n is at 0x1200+4n (n from 0 to 31). Bit x of word n maps to interrupt 32n+x. A read of either window returns the same pending view, and the read is combinational from the address.
- R2: A read bit is 1 when its interrupt is pending, or active and pending. It is 0 otherwise.
- R3: A 0 written in the clear window has no effect. A 1 written in the clear window removes the software-held pending state. It does not change the active state, so active-and-pending becomes active.
- R4: A clear write to an interrupt that is not pending leaves it not pending and leaves its active state as it was.
- R5: A level-sensitive interrupt (edge config 0) reads pending while its line is high, even after a clear write. Once the line falls, it is pending only if a software latch that was set is still held.
- R6: An edge-sensitive interrupt (edge config 1) latches pending on a rising edge of its line, one clock after the edge. A clear write removes the latch even while the line stays high. A rising edge in the same cycle as a clear write leaves the interrupt pending.
- R7: A 1 written in the set window latches pending for that interrupt. It becomes visible one clock later.
- R8: An activate pulse on a pending interrupt sets its active output and drops its software/edge latch. A deactivate pulse clears the active output, and it wins over an activate pulse in the same cycle. An activate pulse on a non-pending interrupt does nothing.
- R9: When the extended range is disabled, every word reads 0 and ignores writes. Words above the configured last-word index also read 0 and ignore writes.
- R10: When the security-off control is 0, non-secure accesses read 0 from secure-group interrupts and their writes to those interrupts are ignored. Secure accesses, or any access when the control is 1, reach every bit.
- R11: Interrupt indices at or above NUM_IRQ are unimplemented. They read 0 and ignore writes.
- R12: After reset, no interrupt is pending or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ext_en | input | 1 | Enables the extended range |
| cfg_last_word | input | 5 | Index of the highest implemented word |
| cfg_sec_off | input | 1 | 1 disables the security split |
| bus_addr | input | 13 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_nonsec | input | 1 | 1 marks the access as non-secure |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq_line | input | MAX_WORDS*32 | Interrupt input lines |
| irq_edge | input | MAX_WORDS*32 | 1 = edge-sensitive, 0 = level-sensitive |
| irq_secure | input | MAX_WORDS*32 | 1 = secure-group interrupt |
| act_pulse | input | MAX_WORDS*32 | Activate request per interrupt |
| deact_pulse | input | MAX_WORDS*32 | Deactivate request per interrupt |
| irq_active | output | MAX_WORDS*32 | Active state per interrupt |

## Verification
The embedded assertions check several rules on every cycle. A disabled range always reads zero. Non-secure reads never show a secure-group bit while the security split is on. Unimplemented bits never read 1. A level-sensitive interrupt with its line high always reads pending. A clear of an edge latch empties it, and a deactivate always drops the active state. Other behaviour needs the bench's scenarios in sequence: the address map, the effect of a zero write, the range and enable controls ignoring writes (seen after they are re-opened), the race between a rising edge and a clear, and the active-and-pending to active transition.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int ADDR_W    = 13;
  localparam int DATA_W    = 32;
  localparam int WORD_IDXW = 5;
  // 128-byte pages: 0x1800 >> 7 and 0x1200 >> 7
  localparam logic [5:0] CLR_PAGE = 6'h30;
  localparam logic [5:0] SET_PAGE = 6'h24;

  typedef struct packed {
    logic                 hit;
    logic                 clr_we;
    logic                 set_we;
    logic [WORD_IDXW-1:0] word;
  } dec_t;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ipc_addr_dec.sv
module ipc_addr_dec
  import ipc_pkg::*;
#(
  parameter int MAX_WORDS = 4
) (
  input  logic                 cfg_ext_en,
  input  logic [WORD_IDXW-1:0] cfg_last_word,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output dec_t                 dec
);
  logic clr_page, set_page, word_ok;

  always_comb begin
    clr_page = (addr[12:7] == CLR_PAGE) && (addr[1:0] == 2'b00);
    set_page = (addr[12:7] == SET_PAGE) && (addr[1:0] == 2'b00);
    word_ok  = cfg_ext_en && (addr[6:2] <= cfg_last_word)
               && (32'(addr[6:2]) < MAX_WORDS);
    dec.word   = addr[6:2];
    dec.hit    = word_ok && (clr_page || set_page);
    dec.clr_we = word_ok && clr_page && wr;
    dec.set_we = word_ok && set_page && wr;
  end
endmodule

// File: rtl/ipc_irq_cell.sv
module ipc_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic edge_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic act_i,
  input  logic deact_i,
  output logic pend_o,
  output logic act_o
);
  logic line_q, latch_q, act_q;
  logic line_d, latch_d, act_d;
  logic rise, take;

  always_comb begin
    rise   = edge_i && line_i && !line_q;
    pend_o = latch_q || (!edge_i && line_i);
    take   = act_i && pend_o;
    line_d = line_i;
    latch_d = latch_q;
    if (clr_i || take) latch_d = 1'b0;
    if (set_i || rise) latch_d = 1'b1;
    act_d = act_q;
    if (take)    act_d = 1'b1;
    if (deact_i) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      latch_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      line_q  <= line_d;
      latch_q <= latch_d;
      act_q   <= act_d;
    end
  end

  assign act_o = act_q;

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i && line_i) |-> pend_o);
  assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && edge_i && !rise && !set_i) |=> !latch_q);
  assert_set_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> latch_q);
  assert_deact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deact_i |=> !act_q);
  assert_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && pend_o && !deact_i) |=> act_q);
endmodule

// File: rtl/ipc_bank.sv
module ipc_bank
  import ipc_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  parameter int NUM_IRQ   = 120,
  localparam int NI       = MAX_WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_en,
  input  logic [4:0]        cfg_last_word,
  input  logic              cfg_sec_off,
  input  logic [12:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_nonsec,
  output logic [31:0]       bus_rdata,
  input  logic [NI-1:0]     irq_line,
  input  logic [NI-1:0]     irq_edge,
  input  logic [NI-1:0]     irq_secure,
  input  logic [NI-1:0]     act_pulse,
  input  logic [NI-1:0]     deact_pulse,
  output logic [NI-1:0]     irq_active
);
  logic          rst_n_s;
  dec_t          dec;
  logic [NI-1:0] pend, vis;

  ipc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  ipc_addr_dec #(.MAX_WORDS(MAX_WORDS)) u_dec (
    .cfg_ext_en(cfg_ext_en), .cfg_last_word(cfg_last_word),
    .addr(bus_addr), .wr(bus_wr), .dec(dec)
  );

  for (genvar i = 0; i < NI; i++) begin : g_irq
    localparam int W = i / 32;
    localparam int B = i % 32;
    logic acc, set_b, clr_b;

    if (i < NUM_IRQ) begin : g_impl
      always_comb begin
        acc   = dec.hit && (32'(dec.word) == W)
                && !(irq_secure[i] && bus_nonsec && !cfg_sec_off);
        set_b = dec.set_we && acc && bus_wdata[B];
        clr_b = dec.clr_we && acc && bus_wdata[B];
      end
    end else begin : g_unimpl
      always_comb begin
        acc   = 1'b0;
        set_b = 1'b0;
        clr_b = 1'b0;
      end
    end

    ipc_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n_s),
      .line_i(irq_line[i]), .edge_i(irq_edge[i]),
      .set_i(set_b), .clr_i(clr_b),
      .act_i(act_pulse[i]), .deact_i(deact_pulse[i]),
      .pend_o(pend[i]), .act_o(irq_active[i])
    );

    assign vis[i] = acc && pend[i];

    assert_secure_mask_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
      (irq_secure[i] && bus_nonsec && !cfg_sec_off && (32'(bus_addr[6:2]) == W))
        |-> !bus_rdata[B]);
    if (i >= NUM_IRQ) begin : g_chk_unimpl
      assert_unimpl_raz_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
        (32'(bus_addr[6:2]) == W) |-> !bus_rdata[B]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < MAX_WORDS; w++) bus_rdata |= vis[w*32 +: 32];
  end

  assert_disabled_raz_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_ext_en |-> (bus_rdata == '0));
endmodule

// File: tb/sim_ipc_bank.sv
`timescale 1ns/1ps
module sim_ipc_bank;
  localparam int MW = 4;
  localparam int NI = MW * 32;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_ext_en, cfg_sec_off, bus_wr, bus_nonsec;
  logic [4:0]  cfg_last_word;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NI-1:0] irq_line, irq_edge, irq_secure, act_pulse, deact_pulse, irq_active;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ipc_bank #(.MAX_WORDS(MW), .NUM_IRQ(120)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ext_en(cfg_ext_en), .cfg_last_word(cfg_last_word),
    .cfg_sec_off(cfg_sec_off), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_nonsec(bus_nonsec), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .irq_edge(irq_edge), .irq_secure(irq_secure),
    .act_pulse(act_pulse), .deact_pulse(deact_pulse), .irq_active(irq_active)
  );

  // op: 0 read-check, 1 set write, 2 clear write | req | addr | data | expected
  localparam int NV = 16;
  localparam logic [82:0] VEC [NV] = '{
    {2'd0, 4'd12, 13'h1800, 32'h0, 32'h0},                // R12 idle state
    {2'd1, 4'd7,  13'h1200, 32'h000000F0, 32'h0},
    {2'd0, 4'd7,  13'h1800, 32'h0, 32'h000000F0},         // R7
    {2'd2, 4'd3,  13'h1800, 32'h00000030, 32'h0},
    {2'd0, 4'd3,  13'h1800, 32'h0, 32'h000000C0},         // R3
    {2'd0, 4'd1,  13'h1200, 32'h0, 32'h000000C0},         // R1 set window reads
    {2'd2, 4'd3,  13'h1800, 32'h0, 32'h0},
    {2'd0, 4'd3,  13'h1800, 32'h0, 32'h000000C0},         // R3 zero write
    {2'd1, 4'd1,  13'h1204, 32'h80000001, 32'h0},
    {2'd0, 4'd1,  13'h1804, 32'h0, 32'h80000001},         // R1 word 1
    {2'd0, 4'd1,  13'h1800, 32'h0, 32'h000000C0},         // R1 no alias
    {2'd2, 4'd2,  13'h1804, 32'hFFFFFFFF, 32'h0},
    {2'd0, 4'd2,  13'h1804, 32'h0, 32'h0},                // R2
    {2'd1, 4'd11, 13'h120C, 32'hFFFFFFFF, 32'h0},
    {2'd0, 4'd11, 13'h180C, 32'h0, 32'h00FFFFFF},         // R11
    {2'd2, 4'd4,  13'h180C, 32'hFFFFFFFF, 32'h0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] op, input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 chk(bus_rdata, exp, tag);
  endtask

  task automatic pulse(input bit activate, input int idx);
    @(negedge clk);
    if (activate) act_pulse[idx] = 1'b1; else deact_pulse[idx] = 1'b1;
    @(negedge clk);
    act_pulse = '0; deact_pulse = '0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_ext_en = 1'b1; cfg_last_word = 5'd3; cfg_sec_off = 1'b1;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_nonsec = 1'b0;
    irq_line = '0; irq_edge = '1; irq_secure = '0; act_pulse = '0; deact_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    #1 chk(32'(irq_active != '0), 32'h0, "R12 active after reset");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][82:81] == 2'd0)
        rd(VEC[k][76:64], VEC[k][31:0], $sformatf("R%0d vector %0d", VEC[k][80:77], k));
      else
        wr(VEC[k][82:81], VEC[k][76:64], VEC[k][63:32]);
    end
    rd(13'h180C, 32'h0, "R11 unimpl after clear");
    wr(2'd2, 13'h1800, 32'hFFFFFFFF);

    // R9: range limit and disable
    cfg_last_word = 5'd1;
    wr(2'd1, 13'h1208, 32'h0000FFFF);
    rd(13'h1808, 32'h0, "R9 word above range");
    cfg_last_word = 5'd3;
    rd(13'h1808, 32'h0, "R9 write above range ignored");
    wr(2'd1, 13'h1208, 32'h00000005);
    cfg_ext_en = 1'b0;
    rd(13'h1808, 32'h0, "R9 disabled reads zero");
    wr(2'd2, 13'h1808, 32'hFFFFFFFF);
    cfg_ext_en = 1'b1;
    rd(13'h1808, 32'h00000005, "R9 disabled write ignored");
    wr(2'd2, 13'h1808, 32'hFFFFFFFF);

    // R10: security
    irq_secure[5] = 1'b1; cfg_sec_off = 1'b0; bus_nonsec = 1'b1;
    wr(2'd1, 13'h1200, 32'h00000020);
    bus_nonsec = 1'b0;
    rd(13'h1800, 32'h0, "R10 nonsecure set ignored");
    wr(2'd1, 13'h1200, 32'h00000020);
    rd(13'h1800, 32'h00000020, "R10 secure set");
    bus_nonsec = 1'b1;
    rd(13'h1800, 32'h0, "R10 nonsecure read masked");
    wr(2'd2, 13'h1800, 32'h00000020);
    cfg_sec_off = 1'b1;
    rd(13'h1800, 32'h00000020, "R10 nonsecure clear ignored, visible with security off");
    wr(2'd2, 13'h1800, 32'h00000020);
    rd(13'h1800, 32'h0, "R10 clear with security off");
    bus_nonsec = 1'b0;

    // R5: level interrupt 40 = word1 bit8
    irq_edge[40] = 1'b0;
    @(negedge clk); irq_line[40] = 1'b1;
    rd(13'h1804, 32'h00000100, "R5 line high pending");
    wr(2'd2, 13'h1804, 32'h00000100);
    rd(13'h1804, 32'h00000100, "R5 clear while high");
    @(negedge clk); irq_line[40] = 1'b0;
    rd(13'h1804, 32'h0, "R5 line low no latch");
    wr(2'd1, 13'h1204, 32'h00000100);
    @(negedge clk); irq_line[40] = 1'b1;
    @(negedge clk); irq_line[40] = 1'b0;
    rd(13'h1804, 32'h00000100, "R5 software latch held");
    wr(2'd2, 13'h1804, 32'h00000100);
    rd(13'h1804, 32'h0, "R5 latch cleared");

    // R6: edge interrupt 41 = word1 bit9
    @(negedge clk); irq_line[41] = 1'b1;
    rd(13'h1804, 32'h00000200, "R6 rising edge latched");
    wr(2'd2, 13'h1804, 32'h00000200);
    rd(13'h1804, 32'h0, "R6 clear with line high");
    @(negedge clk); irq_line[41] = 1'b0;
    @(negedge clk);
    bus_addr = 13'h1804; bus_wdata = 32'h00000200; bus_wr = 1'b1; irq_line[41] = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    #1 chk(bus_rdata, 32'h00000200, "R6 edge wins over clear");
    wr(2'd2, 13'h1804, 32'h00000200);
    irq_line[41] = 1'b0;

    // R8 / R3 / R4: active handshake on interrupt 2
    wr(2'd1, 13'h1200, 32'h00000004);
    pulse(1'b1, 2);
    #1 chk(32'(irq_active[2]), 32'h1, "R8 activate");
    rd(13'h1800, 32'h0, "R8 pending moved to active");
    wr(2'd1, 13'h1200, 32'h00000004);
    rd(13'h1800, 32'h00000004, "R2 active and pending reads 1");
    wr(2'd2, 13'h1800, 32'h00000004);
    rd(13'h1800, 32'h0, "R3 active-and-pending cleared");
    chk(32'(irq_active[2]), 32'h1, "R3 active kept");
    wr(2'd2, 13'h1800, 32'h00000004);
    rd(13'h1800, 32'h0, "R4 clear not pending");
    chk(32'(irq_active[2]), 32'h1, "R4 active unchanged");
    pulse(1'b0, 2);
    #1 chk(32'(irq_active[2]), 32'h0, "R8 deactivate");
    pulse(1'b1, 3);
    #1 chk(32'(irq_active[3]), 32'h0, "R8 activate not pending ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule